// File: doc/BRIEF.md
# Software-Serviced AXI-Lite Subordinate Bridge

This block lets a control processor stand in for an AXI-Lite subordinate. An external manager issues reads and writes on a normal AXI-Lite port. The bridge captures each command, and the write data that goes with it, and holds them until software collects them through a small 32-bit register port. Software then supplies the read data or the write acknowledge. The bridge drives that answer back to the manager and records that it was accepted.

Only one transaction per direction is open at a time. The address and data ready outputs stay low from the moment a command is captured until its response handshake completes. Reading the command and data registers consumes them, and the completion flags clear when they are read. A level interrupt tells software that a command is waiting. Responses are always OKAY. Bursts, byte strobes and protection bits are not used.

Top module: `axil_sw_bridge`

## Requirements
- R1: After reset, arready, awready and wready are 1, rvalid, bvalid and irq are 0, and every register reads as 0.
- R2: When arvalid and arready are both high at a clock edge, arready is low from the next cycle. The control register then shows bit 8 = 1, and register 0x04 returns the captured address in bits 31:2, 0 in bit 1 and 1 in bit 0.
- R3: A register read of 0x04 clears its bit 0 and control bit 8 for later reads. The captured address is kept.
- R4: A register write to 0x0C drives rvalid high in the next cycle, with rdata equal to the written word and rresp = 2'b00. rvalid and rdata hold until rready is sampled high. arready stays low until that R handshake, and it is high in the cycle after.
- R5: An R handshake sets control bit 10. That bit clears after the next read of the control register, and the read that clears it still returns 1.
- R6: An AW handshake and a W handshake drop awready and wready and set control bits 9 and 11. Register 0x08 returns the write address in bits 31:2 with bit 0 = 1. Register 0x10 returns the write data. Reading 0x08 clears bit 9 and bit 0 of 0x08. Reading 0x10 clears bit 11.
- R7: Writing a word with bit 0 = 1 to 0x14 raises bvalid in the next cycle, with bresp = 2'b00. Writing bit 0 = 0 has no effect. bvalid holds until bready. The B handshake sets control bit 12, which clears on a control read, and reopens awready and wready.
- R8: Control bits 0 and 1 are read/write interrupt enables. irq is 1 one cycle after (read pending AND bit 0) OR (write pending AND bit 1) becomes true, and returns to 0 one cycle after the condition ends.
- R9: When a control read and an R handshake fall on the same clock edge, the setting by hardware wins. Bit 10 reads 1 on the following control read.
- R10: Register offsets 0x18 and 0x1C read as 0. Writes to the read-only registers 0x04 and 0x08 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | 32 | Read address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | 32 | Write address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| regAddr | input | 5 | Register byte offset |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid while regRd is high |
| irq | output | 1 | Level interrupt |

## Verification
A pending or open flag that is wrong for its channel shows at the ports in one of two ways: a ready line stays low after its transaction should have retired, or a second command is accepted too early. Either is visible in the cycle after the handshake. A consume or clear-on-read that misfires shows up on the next register read as a status bit that is wrong, so every consuming read is followed by a second read. A wrong precedence or enable decode shows one cycle later, on control bit 10 or on irq. The response path is checked while the manager stalls, which shows whether rdata and the valid lines are held.

// File: rtl/axil_sw_pkg.sv
package axil_sw_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned REG_AW = 5;
  localparam int unsigned IDX_W = REG_AW - 2;

  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_RDCMD = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_WRCMD = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_RDATA = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_WDATA = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_WRESP = IDX_W'(5);

  localparam int unsigned BIT_EN_RD   = 0;
  localparam int unsigned BIT_EN_WR   = 1;
  localparam int unsigned BIT_AR_PEND = 8;
  localparam int unsigned BIT_AW_PEND = 9;
  localparam int unsigned BIT_R_DONE  = 10;
  localparam int unsigned BIT_W_PEND  = 11;
  localparam int unsigned BIT_B_DONE  = 12;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic rdCtrl;
    logic rdRdCmd;
    logic rdWrCmd;
    logic rdWdata;
    logic wrCtrl;
    logic wrRdata;
    logic wrWresp;
  } regStrobe_t;

  typedef struct packed {
    logic [1:0] intEn;
    logic       arPend;
    logic       awPend;
    logic       wPend;
    logic       rDone;
    logic       bDone;
    logic       bValid;
  } regStatus_t;
endpackage

// File: rtl/axil_sw_slot.sv
module axil_sw_slot #(
  parameter int unsigned W_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [W_BITS-1:0] inWord,
  input  logic              consume,
  input  logic              retire,
  output logic              pend,
  output logic [W_BITS-1:0] wordQ
);
  logic openQ;
  logic capture;

  assign inReady = !openQ;
  assign capture = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ <= 1'b0;
      pend  <= 1'b0;
      wordQ <= '0;
    end else begin
      if (capture)     openQ <= 1'b1;
      else if (retire) openQ <= 1'b0;

      if (capture)      pend <= 1'b1;
      else if (consume) pend <= 1'b0;

      if (capture) wordQ <= inWord;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady) else $error("slot accepted twice"); // R2, R6
endmodule

// File: rtl/axil_sw_ctrl.sv
module axil_sw_ctrl import axil_sw_pkg::*; (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  regStatus_t        stat,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [DATA_W-1:0] rData,
  input  logic [DATA_W-1:0] wData,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdata
);
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] ctrlWord;

  assign idx = regAddr[REG_AW-1:2];

  always_comb begin
    strobe = '0;
    strobe.rdCtrl  = regRd && (idx == IDX_CTRL);
    strobe.rdRdCmd = regRd && (idx == IDX_RDCMD);
    strobe.rdWrCmd = regRd && (idx == IDX_WRCMD);
    strobe.rdWdata = regRd && (idx == IDX_WDATA);
    strobe.wrCtrl  = regWr && (idx == IDX_CTRL);
    strobe.wrRdata = regWr && (idx == IDX_RDATA);
    strobe.wrWresp = regWr && (idx == IDX_WRESP);
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_EN_RD]   = stat.intEn[0];
    ctrlWord[BIT_EN_WR]   = stat.intEn[1];
    ctrlWord[BIT_AR_PEND] = stat.arPend;
    ctrlWord[BIT_AW_PEND] = stat.awPend;
    ctrlWord[BIT_R_DONE]  = stat.rDone;
    ctrlWord[BIT_W_PEND]  = stat.wPend;
    ctrlWord[BIT_B_DONE]  = stat.bDone;
  end

  always_comb begin
    regRdata = '0;
    unique case (idx)
      IDX_CTRL:  regRdata = ctrlWord;
      IDX_RDCMD: regRdata = {arAddr[ADDR_W-1:2], 1'b0, stat.arPend};
      IDX_WRCMD: regRdata = {awAddr[ADDR_W-1:2], 1'b0, stat.awPend};
      IDX_RDATA: regRdata = rData;
      IDX_WDATA: regRdata = wData;
      IDX_WRESP: regRdata = {{(DATA_W-1){1'b0}}, stat.bValid};
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/axil_sw_dp.sv
module axil_sw_dp import axil_sw_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output regStatus_t        stat,
  output logic [ADDR_W-1:0] arAddr,
  output logic [ADDR_W-1:0] awAddr,
  output logic [DATA_W-1:0] wData,
  output logic              irq
);
  logic [1:0] intEn;
  logic rValidQ, bValidQ, rDoneQ, bDoneQ, irqQ;
  logic [DATA_W-1:0] rDataQ;
  logic arPend, awPend, wPend;
  logic rHs, bHs;

  assign rHs = rValidQ && rready;
  assign bHs = bValidQ && bready;

  axil_sw_slot #(.W_BITS(ADDR_W)) uArSlot (
    .clk(clk), .rstN(rstN), .inValid(arvalid), .inReady(arready), .inWord(araddr),
    .consume(strobe.rdRdCmd), .retire(rHs), .pend(arPend), .wordQ(arAddr));

  axil_sw_slot #(.W_BITS(ADDR_W)) uAwSlot (
    .clk(clk), .rstN(rstN), .inValid(awvalid), .inReady(awready), .inWord(awaddr),
    .consume(strobe.rdWrCmd), .retire(bHs), .pend(awPend), .wordQ(awAddr));

  axil_sw_slot #(.W_BITS(DATA_W)) uWSlot (
    .clk(clk), .rstN(rstN), .inValid(wvalid), .inReady(wready), .inWord(wdata),
    .consume(strobe.rdWdata), .retire(bHs), .pend(wPend), .wordQ(wData));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn   <= '0;
      rValidQ <= 1'b0;
      rDataQ  <= '0;
      bValidQ <= 1'b0;
      rDoneQ  <= 1'b0;
      bDoneQ  <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (strobe.wrCtrl) intEn <= regWdata[BIT_EN_WR:BIT_EN_RD];

      if (rHs)                 rValidQ <= 1'b0;
      else if (strobe.wrRdata) rValidQ <= 1'b1;
      if (strobe.wrRdata && !rValidQ) rDataQ <= regWdata;

      if (bHs)                                  bValidQ <= 1'b0;
      else if (strobe.wrWresp && regWdata[0])   bValidQ <= 1'b1;

      // hardware set takes precedence over clear-on-read
      if (rHs)                rDoneQ <= 1'b1;
      else if (strobe.rdCtrl) rDoneQ <= 1'b0;
      if (bHs)                bDoneQ <= 1'b1;
      else if (strobe.rdCtrl) bDoneQ <= 1'b0;

      irqQ <= (arPend && intEn[0]) || (awPend && intEn[1]);
    end
  end

  assign rvalid = rValidQ;
  assign rdata  = rDataQ;
  assign rresp  = RESP_OKAY;
  assign bvalid = bValidQ;
  assign bresp  = RESP_OKAY;
  assign irq    = irqQ;

  always_comb begin
    stat.intEn  = intEn;
    stat.arPend = arPend;
    stat.awPend = awPend;
    stat.wPend  = wPend;
    stat.rDone  = rDoneQ;
    stat.bDone  = bDoneQ;
    stat.bValid = bValidQ;
  end

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rvalid && !rready) |=> (rvalid && $stable(rdata))) else $error("R dropped"); // R4
  AST_R_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (rvalid && rready) |=> stat.rDone) else $error("R done lost"); // R9
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bvalid && !bready) |=> bvalid) else $error("B dropped"); // R7
  AST_B_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (bvalid && bready) |=> (stat.bDone && !bvalid)) else $error("B done lost"); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (stat.intEn == 2'b00) |=> !irq) else $error("irq while masked"); // R8
endmodule

// File: rtl/axil_sw_bridge.sv
module axil_sw_bridge import axil_sw_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  regStrobe_t        strobe;
  regStatus_t        stat;
  logic [ADDR_W-1:0] arAddr, awAddr;
  logic [DATA_W-1:0] wData;

  axil_sw_ctrl uCtrl (
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .stat(stat),
    .arAddr(arAddr), .awAddr(awAddr), .rData(rdata), .wData(wData),
    .strobe(strobe), .regRdata(regRdata));

  axil_sw_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .stat(stat), .arAddr(arAddr), .awAddr(awAddr), .wData(wData), .irq(irq));
endmodule

// File: tb/sim_axil_sw_bridge.sv
module sim_axil_sw_bridge;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arvalid = 0, rready = 0, awvalid = 0, wvalid = 0, bready = 0;
  logic [31:0] araddr = '0, awaddr = '0, wdata = '0;
  logic arready, rvalid, awready, wready, bvalid, irq;
  logic [31:0] rdata, regRdata;
  logic [1:0] rresp, bresp;
  logic [4:0] regAddr = '0;
  logic regRd = 0, regWr = 0;
  logic [31:0] regWdata = '0;

  int nChecks = 0;
  int nErrors = 0;

  always #(PERIOD/2) clk = ~clk;

  axil_sw_bridge u0 (
    .clk(clk), .rstN(rstN),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic sendAr(input logic [31:0] a);
    @(negedge clk);
    arvalid = 1'b1; araddr = a;
    @(negedge clk);
    arvalid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 arready", arready, 1);
    check("R1 awready", awready, 1);
    check("R1 wready", wready, 1);
    check("R1 rvalid", rvalid, 0);
    check("R1 bvalid", bvalid, 0);
    check("R1 irq", irq, 0);
    regRead(5'h00, d); check("R1 ctrl", d, 32'h0);
    regRead(5'h04, d); check("R1 rdcmd", d, 32'h0);
    regRead(5'h14, d); check("R1 wresp", d, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    regWrite(5'h00, 32'h1);
    sendAr(32'h1234_5678);
    check("R2 arready low", arready, 0);
    @(negedge clk);
    check("R8 irq raised", irq, 1);
    regRead(5'h00, d); check("R2 ctrl", d, 32'h101);
    regRead(5'h04, d); check("R2 rdcmd", d, 32'h1234_5679);
    regRead(5'h04, d); check("R3 rdcmd consumed", d, 32'h1234_5678);
    regRead(5'h00, d); check("R3 ctrl consumed", d, 32'h001);
    @(negedge clk);
    check("R8 irq dropped", irq, 0);
    check("R4 arready held", arready, 0);
    regWrite(5'h0C, 32'hCAFE_F00D);
    check("R4 rvalid", rvalid, 1);
    check("R4 rdata", rdata, 32'hCAFE_F00D);
    check("R4 rresp", rresp, 0);
    repeat (3) @(negedge clk);
    check("R4 rvalid hold", rvalid, 1);
    check("R4 rdata hold", rdata, 32'hCAFE_F00D);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    check("R4 rvalid cleared", rvalid, 0);
    check("R4 arready reopened", arready, 1);
    regRead(5'h00, d); check("R5 done set", d, 32'h401);
    regRead(5'h00, d); check("R5 done cleared", d, 32'h001);
  endtask

  task automatic t_write();
    logic [31:0] d;
    regWrite(5'h00, 32'h2);
    @(negedge clk);
    awvalid = 1'b1; awaddr = 32'h0000_00A0; wvalid = 1'b1; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    check("R6 awready low", awready, 0);
    check("R6 wready low", wready, 0);
    @(negedge clk);
    check("R8 irq write", irq, 1);
    regRead(5'h00, d); check("R6 ctrl", d, 32'hA02);
    regRead(5'h08, d); check("R6 wrcmd", d, 32'h0000_00A1);
    regRead(5'h10, d); check("R6 wdata", d, 32'hDEAD_BEEF);
    regRead(5'h00, d); check("R6 ctrl consumed", d, 32'h002);
    check("R7 awready held", awready, 0);
    regWrite(5'h14, 32'h0);
    check("R7 zero ignored", bvalid, 0);
    regWrite(5'h14, 32'h1);
    check("R7 bvalid", bvalid, 1);
    check("R7 bresp", bresp, 0);
    repeat (2) @(negedge clk);
    check("R7 bvalid hold", bvalid, 1);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    check("R7 bvalid cleared", bvalid, 0);
    check("R7 awready reopened", awready, 1);
    check("R7 wready reopened", wready, 1);
    regRead(5'h00, d); check("R7 bdone set", d, 32'h1002);
    regRead(5'h00, d); check("R7 bdone cleared", d, 32'h002);
  endtask

  task automatic t_precedence();
    logic [31:0] d;
    sendAr(32'h0000_0040);
    @(negedge clk);
    check("R8 irq masked", irq, 0);
    regRead(5'h04, d); check("R2 rdcmd second", d, 32'h0000_0041);
    regWrite(5'h0C, 32'h0000_0055);
    check("R4 rvalid second", rvalid, 1);
    @(negedge clk);
    rready = 1'b1; regAddr = 5'h00; regRd = 1'b1;
    #1 d = regRdata;
    check("R9 old value", d, 32'h002);
    @(negedge clk);
    rready = 1'b0; regRd = 1'b0;
    regRead(5'h00, d); check("R9 hw wins", d, 32'h402);
    regRead(5'h00, d); check("R9 cleared later", d, 32'h002);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    regRead(5'h18, d); check("R10 0x18", d, 32'h0);
    regRead(5'h1C, d); check("R10 0x1C", d, 32'h0);
    regWrite(5'h04, 32'hFFFF_FFFF);
    regWrite(5'h08, 32'hFFFF_FFFF);
    regRead(5'h04, d); check("R10 rdcmd unchanged", d, 32'h0000_0040);
    regRead(5'h08, d); check("R10 wrcmd unchanged", d, 32'h0000_00A0);
    regRead(5'h00, d); check("R10 ctrl unchanged", d, 32'h002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_precedence();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule